// File: doc/BRIEF.md
# Programmable Serial Audio Frame Transmitter

This block sends audio samples out on a three-wire serial link: a bit clock, a frame sync and a data line. It is master of both clocks. The bit clock is derived from the block's own clock through an even divider, and every frame is laid out from configuration inputs: the number of words in a frame, a separate bit width for the first word and for all later words, the FIFO bit sent first and the direction of the walk through the word, the length and polarity of the frame sync, an option to raise the sync one bit clock ahead of the frame, and the bit clock edge that launches data.

Samples are written as 32-bit words into a 32-entry FIFO. A DMA request is raised while the FIFO level is at or below a watermark. When a word is due and the FIFO is empty, the word goes out as zeros and a sticky error flag is set, which can drive an interrupt. Transmission starts only when the transmitter, bit clock and channel enables are all high. When they drop, the frame in progress is completed and the lines go back to their idle levels.

Top module: `i2s_frame_tx`

## Requirements
- R1: The bit clock period is 2*(cfg_div+1) clock cycles. Data changes on the launch edge and is stable at the sample edge. The sample edge is the rising edge of bclk when cfg_bclk_inv=0 and the falling edge when it is 1. When idle, bclk rests at the level of cfg_bclk_inv.
- R2: A frame holds cfg_frame_words_m1+1 words. Word 0 carries cfg_first_width_m1+1 bits and every later word carries cfg_other_width_m1+1 bits. Each word consumes one FIFO entry.
- R3: Bit b (counted from 0) of a word takes FIFO bit cfg_start_bit-b when cfg_msb_first=1, and bit cfg_start_bit+b when it is 0, both taken modulo 32.
- R4: The frame sync is active for the first cfg_sync_len_m1+1 bit clocks of each frame. Active means high when cfg_sync_low=0 and low when it is 1. Outside the pulse, and when idle, fsync holds the inactive level.
- R5: With cfg_sync_early=1 the sync pulse keeps its length but starts one bit clock earlier. Before the first frame after a start, one lead bit with data 0 and sync active is sent. The pulse is also asserted on the last bit of a frame that is followed by another frame.
- R6: No bit clock edge is produced and no FIFO entry is consumed unless tx_en, bclk_en and chan_en are all 1.
- R7: When the enables drop, the current frame completes in full. The block then stops, with bclk, fsync and sdata at their idle levels.
- R8: The FIFO holds 32 words. push_ready is low when it is full, and a push made while it is full is ignored. fifo_level reports the number of stored words.
- R9: dma_req is high exactly when dma_en is 1 and fifo_level is less than or equal to cfg_watermark.
- R10: A word that is due while the FIFO is empty is sent as all zeros and sets err_flag. err_flag stays set until a cycle with err_clear high and no new underrun. irq equals err_flag gated by err_irq_en.
- R11: After reset the FIFO is empty, err_flag is 0, and the serial lines are at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Bit clock divider, period 2*(cfg_div+1) |
| cfg_frame_words_m1 | input | 5 | Words per frame minus one |
| cfg_sync_len_m1 | input | 5 | Frame sync length in bit clocks minus one |
| cfg_first_width_m1 | input | 5 | Word 0 width minus one |
| cfg_other_width_m1 | input | 5 | Width of later words minus one |
| cfg_start_bit | input | 5 | FIFO word bit sent first |
| cfg_msb_first | input | 1 | 1: walk bit index downward |
| cfg_sync_early | input | 1 | 1: sync starts one bit early |
| cfg_sync_low | input | 1 | 1: sync active low |
| cfg_bclk_inv | input | 1 | Bit clock polarity and idle level |
| cfg_watermark | input | 5 | DMA request threshold |
| tx_en | input | 1 | Transmitter enable |
| bclk_en | input | 1 | Bit clock enable |
| chan_en | input | 1 | Channel enable |
| dma_en | input | 1 | DMA request enable |
| err_irq_en | input | 1 | Underrun interrupt enable |
| err_clear | input | 1 | Clears err_flag when high |
| push_valid | input | 1 | Write a word into the FIFO |
| push_data | input | 32 | Word to write |
| push_ready | output | 1 | FIFO not full |
| fifo_level | output | 6 | Words held in the FIFO |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| dma_req | output | 1 | DMA request |
| err_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt |

## Verification
The in-line properties watch, on every cycle, the FIFO occupancy bound and the refusal of pushes when full. They also check that err_flag holds until it is cleared, that an underrun word leaves the line at zero, that a start happens only with all enables set, and that an idle block keeps the serial lines at their resting levels. Frame layout can only be shown by the bench's scenarios, which decode the serial stream at the sample edges and compare it with a stream built from the configuration. This covers word widths, bit walk and wrap, sync length, polarity and the early lead bit, the finish-the-frame stop, and the measured bit clock period.

// File: rtl/i2s_frame_tx.sv
module i2s_frame_tx #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int DIVW  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIVW-1:0]              cfg_div,
  input  logic [$clog2(DW)-1:0]        cfg_frame_words_m1,
  input  logic [$clog2(DW)-1:0]        cfg_sync_len_m1,
  input  logic [$clog2(DW)-1:0]        cfg_first_width_m1,
  input  logic [$clog2(DW)-1:0]        cfg_other_width_m1,
  input  logic [$clog2(DW)-1:0]        cfg_start_bit,
  input  logic                         cfg_msb_first,
  input  logic                         cfg_sync_early,
  input  logic                         cfg_sync_low,
  input  logic                         cfg_bclk_inv,
  input  logic [$clog2(DEPTH)-1:0]     cfg_watermark,
  input  logic                         tx_en,
  input  logic                         bclk_en,
  input  logic                         chan_en,
  input  logic                         dma_en,
  input  logic                         err_irq_en,
  input  logic                         err_clear,
  input  logic                         push_valid,
  input  logic [DW-1:0]                push_data,
  output logic                         push_ready,
  output logic [$clog2(DEPTH):0]       fifo_level,
  output logic                         bclk,
  output logic                         fsync,
  output logic                         sdata,
  output logic                         dma_req,
  output logic                         err_flag,
  output logic                         irq
);
  localparam int IW = $clog2(DW);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = 2 * IW;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  // transmit FIFO
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level;
  logic          empty, push_ok, pop;

  assign empty      = (level == '0);
  assign push_ready = (level != FULL);
  assign push_ok    = push_valid && push_ready;
  assign fifo_level = level;
  assign dma_req    = dma_en && (level <= {1'b0, cfg_watermark});

  always_ff @(posedge clk) if (push_ok) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      level <= level + (push_ok ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  // serial engine state
  logic            run, active_q, bck_q, pre_q, last_q, cont_q, sd_q, fs_q;
  logic [DIVW-1:0] div_q;
  logic [IW-1:0]   w_q, b_q;
  logic [TW-1:0]   t_q;
  logic [DW-1:0]   cur_q;

  assign run = tx_en && bclk_en && chan_en;

  logic tick, step, stop, launch, take, under;
  assign tick   = active_q && (div_q == cfg_div);
  assign step   = tick && bck_q;
  assign stop   = step && last_q && !cont_q && !pre_q;
  assign launch = (!active_q && run) || (step && !stop);

  // position of the bit about to be launched
  logic [IW-1:0] wl_cur, e_w, e_b, e_wl, e_idx;
  logic [TW-1:0] e_t, sync_m1;
  logic          e_pre, e_last, e_fs;
  logic [DW-1:0] src_word;

  assign wl_cur  = (w_q == '0) ? cfg_first_width_m1 : cfg_other_width_m1;
  assign sync_m1 = {{(TW-IW){1'b0}}, cfg_sync_len_m1};

  always_comb begin
    e_pre = 1'b0;
    e_w   = '0;
    e_b   = '0;
    e_t   = '0;
    if (!active_q) begin
      e_pre = cfg_sync_early;
    end else if (!(pre_q || last_q)) begin
      if (b_q == wl_cur) begin
        e_w = w_q + 1'b1;
      end else begin
        e_w = w_q;
        e_b = b_q + 1'b1;
      end
      e_t = t_q + 1'b1;
    end
  end

  assign e_wl     = (e_w == '0) ? cfg_first_width_m1 : cfg_other_width_m1;
  assign e_last   = !e_pre && (e_w == cfg_frame_words_m1) && (e_b == e_wl);
  assign e_idx    = cfg_msb_first ? (cfg_start_bit - e_b) : (cfg_start_bit + e_b);
  assign src_word = (e_b == '0) ? (empty ? '0 : mem[rd_ptr]) : cur_q;
  assign e_fs     = e_pre ||
                    (cfg_sync_early ? ((e_t < sync_m1) || (e_last && run))
                                    : (e_t <= sync_m1));

  assign take  = launch && !e_pre && (e_b == '0);
  assign pop   = take && !empty;
  assign under = take && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bck_q    <= 1'b0;
      div_q    <= '0;
      pre_q    <= 1'b0;
      last_q   <= 1'b0;
      cont_q   <= 1'b0;
      w_q      <= '0;
      b_q      <= '0;
      t_q      <= '0;
      cur_q    <= '0;
      sd_q     <= 1'b0;
      fs_q     <= 1'b0;
    end else if (stop) begin
      active_q <= 1'b0;
      bck_q    <= 1'b0;
      div_q    <= '0;
      sd_q     <= 1'b0;
      fs_q     <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      if (active_q) div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)     bck_q <= ~bck_q;
      if (launch) begin
        active_q <= 1'b1;
        pre_q    <= e_pre;
        w_q      <= e_w;
        b_q      <= e_b;
        t_q      <= e_t;
        last_q   <= e_last;
        cont_q   <= run;
        if (e_b == '0) cur_q <= src_word;
        sd_q     <= e_pre ? 1'b0 : src_word[e_idx];
        fs_q     <= e_fs;
      end
    end
  end

  assign bclk  = bck_q ^ cfg_bclk_inv;
  assign fsync = fs_q ^ cfg_sync_low;
  assign sdata = sd_q;

  // underrun flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (under)     err_flag <= 1'b1;
    else if (err_clear) err_flag <= 1'b0;
  end
  assign irq = err_flag && err_irq_en;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL && !pop) |=> (level == FULL)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag); // R10
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> !sdata); // R10
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(run)); // R6
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (bclk == cfg_bclk_inv && fsync == cfg_sync_low && !sdata)); // R4
endmodule

// File: tb/test_i2s_frame_tx.sv
module test_i2s_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  cfg_div = 8'd0;
  logic [4:0]  cfg_frm = 5'd0, cfg_sw = 5'd0, cfg_w0 = 5'd0, cfg_wn = 5'd0, cfg_fb = 5'd0;
  logic        cfg_msb = 1'b1, cfg_early = 1'b0, cfg_fsl = 1'b0, cfg_bcp = 1'b0;
  logic [4:0]  cfg_wm = 5'd4;
  logic        tx_en = 0, bclk_en = 0, chan_en = 0, dma_en = 0, irq_en = 0, err_clear = 0;
  logic        push_valid = 0;
  logic [31:0] push_data = '0;
  logic        push_ready, bclk, fsync, sdata, dma_req, err_flag, irq;
  logic [5:0]  fifo_level;

  i2s_frame_tx i_i2s_frame_tx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_frame_words_m1(cfg_frm),
    .cfg_sync_len_m1(cfg_sw), .cfg_first_width_m1(cfg_w0), .cfg_other_width_m1(cfg_wn),
    .cfg_start_bit(cfg_fb), .cfg_msb_first(cfg_msb), .cfg_sync_early(cfg_early),
    .cfg_sync_low(cfg_fsl), .cfg_bclk_inv(cfg_bcp), .cfg_watermark(cfg_wm),
    .tx_en(tx_en), .bclk_en(bclk_en), .chan_en(chan_en), .dma_en(dma_en),
    .err_irq_en(irq_en), .err_clear(err_clear), .push_valid(push_valid),
    .push_data(push_data), .push_ready(push_ready), .fifo_level(fifo_level),
    .bclk(bclk), .fsync(fsync), .sdata(sdata), .dma_req(dma_req),
    .err_flag(err_flag), .irq(irq));

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample-edge monitor: decodes sdata and active sync
  logic sd_cap [256];
  logic fs_cap [256];
  int   mon_cnt = 0, per_bad = 0, per_exp = 2, cyc = 0, last_edge = -1;
  logic prev_bclk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && prev_bclk == cfg_bcp && bclk != cfg_bcp) begin
      if (mon_cnt < 256) begin
        sd_cap[mon_cnt] = sdata;
        fs_cap[mon_cnt] = fsync ^ cfg_fsl;
      end
      mon_cnt++;
      if (last_edge >= 0 && (cyc - last_edge) != per_exp) per_bad++;
      last_edge = cyc;
    end
    prev_bclk = bclk;
  end

  task automatic do_reset();
    tx_en = 0; bclk_en = 0; chan_en = 0; err_clear = 0; push_valid = 0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_cnt = 0; per_bad = 0; last_edge = -1;
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int c, input int k);
    return 32'h9E3779B9 * (k + 1) ^ (32'h01010101 * (c + 3));
  endfunction

  // div, frame_m1, sync_m1, w0_m1, wn_m1, start_bit, msb, early, sync_low, bclk_inv
  localparam logic [36:0] VEC [5] = '{
    {8'd1, 5'd1, 5'd23, 5'd23, 5'd23, 5'd31, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'd0, 5'd2, 5'd0,  5'd7,  5'd3,  5'd7,  1'b1, 1'b0, 1'b0, 1'b0},
    {8'd2, 5'd0, 5'd3,  5'd15, 5'd15, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0},
    {8'd0, 5'd3, 5'd4,  5'd4,  5'd5,  5'd30, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'd3, 5'd1, 5'd0,  5'd31, 5'd31, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic exp_sd [256];
  logic exp_fs [256];

  task automatic run_case(input int c);
    int nw, fbits, nexp, mism, first_bad;
    {cfg_div, cfg_frm, cfg_sw, cfg_w0, cfg_wn, cfg_fb, cfg_msb, cfg_early, cfg_fsl, cfg_bcp} = VEC[c];
    per_exp = 2 * (int'(cfg_div) + 1);
    do_reset();
    nw = 2 * (int'(cfg_frm) + 1);
    for (int k = 0; k < nw; k++) push(pat(c, k));
    // expected stream (R2 R3 R4 R5)
    fbits = 0;
    for (int w = 0; w <= int'(cfg_frm); w++) fbits += ((w == 0) ? int'(cfg_w0) : int'(cfg_wn)) + 1;
    nexp = 0;
    if (cfg_early) begin exp_sd[0] = 1'b0; exp_fs[0] = 1'b1; nexp = 1; end
    for (int f = 0; f < 2; f++) begin
      int t = 0;
      for (int w = 0; w <= int'(cfg_frm); w++) begin
        int wl = ((w == 0) ? int'(cfg_w0) : int'(cfg_wn)) + 1;
        logic [31:0] d = pat(c, f * (int'(cfg_frm) + 1) + w);
        for (int b = 0; b < wl; b++) begin
          logic [4:0] idx = cfg_msb ? cfg_fb - 5'(b) : cfg_fb + 5'(b);
          exp_sd[nexp] = d[idx];
          exp_fs[nexp] = cfg_early ? ((t < int'(cfg_sw)) || (t == fbits - 1 && f == 0))
                                   : (t <= int'(cfg_sw));
          nexp++; t++;
        end
      end
    end
    @(negedge clk); tx_en = 1; bclk_en = 1; chan_en = 1;
    wait (mon_cnt == fbits + (cfg_early ? 1 : 0) + 1);
    @(negedge clk); tx_en = 0;
    repeat ((2 * fbits + 4) * per_exp + 20) @(negedge clk);
    mism = 0; first_bad = -1;
    for (int i = 0; i < nexp && i < mon_cnt; i++)
      if (sd_cap[i] !== exp_sd[i] || fs_cap[i] !== exp_fs[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    check(mism == 0, $sformatf("R2/R3/R4/R5 case %0d stream mismatch at bit", c), first_bad, -1);
    check(mon_cnt == nexp, $sformatf("R7 case %0d bit count", c), mon_cnt, nexp);
    check(per_bad == 0, $sformatf("R1 case %0d bclk period errors", c), per_bad, 0);
    check(bclk == cfg_bcp, $sformatf("R1 case %0d idle bclk", c), bclk, cfg_bcp);
    check(fsync == cfg_fsl, $sformatf("R4 case %0d idle fsync", c), fsync, cfg_fsl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11 reset state
    cfg_bcp = 1; cfg_fsl = 1; dma_en = 1;
    do_reset();
    check(fifo_level == 0, "R11 level", fifo_level, 0);
    check(!err_flag, "R11 err_flag", err_flag, 0);
    check(bclk == 1 && fsync == 1 && !sdata, "R11 idle lines", {bclk, fsync, sdata}, 3'b110);
    check(dma_req == 1, "R9 dma_req at empty", dma_req, 1);
    dma_en = 0; @(negedge clk);
    check(dma_req == 0, "R9 dma_req disabled", dma_req, 0);

    for (int c = 0; c < 5; c++) run_case(c);

    // R6 missing channel enable
    cfg_div = 0; cfg_bcp = 0; cfg_fsl = 0; cfg_early = 0;
    do_reset();
    push(32'h1234_5678); push(32'h0F0F_0F0F);
    tx_en = 1; bclk_en = 1; chan_en = 0;
    repeat (100) @(negedge clk);
    check(mon_cnt == 0, "R6 no bit clock without chan_en", mon_cnt, 0);
    check(fifo_level == 2, "R6 no pop without chan_en", fifo_level, 2);
    tx_en = 0; bclk_en = 0;

    // R8 full FIFO, R9 watermark
    do_reset();
    dma_en = 1; cfg_wm = 5;
    for (int k = 0; k < 6; k++) push(32'(k));
    check(dma_req == 0, "R9 level 6 above watermark 5", dma_req, 0);
    do_reset();
    for (int k = 0; k < 5; k++) push(32'(k));
    check(dma_req == 1, "R9 level 5 at watermark 5", dma_req, 1);
    for (int k = 5; k < 32; k++) push(32'(k));
    check(fifo_level == 32 && !push_ready, "R8 full", fifo_level, 32);
    push(32'hDEAD_BEEF);
    check(fifo_level == 32, "R8 push when full ignored", fifo_level, 32);

    // R10 underrun: frame of two 8-bit words, only one word present
    cfg_div = 0; cfg_frm = 1; cfg_sw = 0; cfg_w0 = 7; cfg_wn = 7; cfg_fb = 7;
    cfg_msb = 1; cfg_early = 0; cfg_fsl = 0; cfg_bcp = 0; per_exp = 2; irq_en = 1;
    do_reset();
    push(32'h0000_00A5);
    tx_en = 1; bclk_en = 1; chan_en = 1;
    wait (mon_cnt == 2);
    @(negedge clk); tx_en = 0;
    repeat (80) @(negedge clk);
    begin
      logic [15:0] got = '0;
      for (int i = 0; i < 16; i++) got[15 - i] = sd_cap[i];
      check(mon_cnt == 16, "R10 underrun frame length", mon_cnt, 16);
      check(got == 16'hA500, "R10 underrun word sent as zeros", got, 16'hA500);
    end
    check(err_flag == 1, "R10 err_flag set", err_flag, 1);
    check(irq == 1, "R10 irq with enable", irq, 1);
    irq_en = 0; @(negedge clk);
    check(irq == 0, "R10 irq masked", irq, 0);
    repeat (5) @(negedge clk);
    check(err_flag == 1, "R10 err_flag sticky", err_flag, 1);
    err_clear = 1; @(negedge clk); err_clear = 0; @(negedge clk);
    check(err_flag == 0, "R10 err_flag cleared", err_flag, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule